// File: doc/BRIEF.md
# Two-Phase Reseeding Scan Pattern Source

This block supplies scan-in data to a set of scan trees for logic self test. One small linear feedback shift register (LFSR) is shared by two phases. In the weighted pseudorandom phase, each tree receives a biased bit stream. The bias comes from combining two LFSR bits per tree, and a per-tree code can switch a tree off entirely.

In the deterministic phase, a seed is captured into the LFSR and into a shadow register. The trees are then loaded one group at a time. While a group is filled, one external variable bit per cycle is XORed into the LFSR feedback. Between groups the shadow register copies the seed back into the LFSR in a single cycle, so every group starts from the same state. Only the active group has its scan enables raised; every other group holds its contents.

A start pulse launches a run. A one-cycle done pulse ends it, and the block then returns to idle with all enables low.

Top module: `lp_reseed_bist`

## Requirements
- R1: `start` is sampled only when the block is idle; the value of `phaseSel` at that edge fixes the phase for the whole run (0 = weighted pseudorandom, 1 = deterministic). A `start` or `phaseSel` change during a run has no effect on its outputs or its length.
- R2: The edge that accepts `start` loads `seedIn` into both the LFSR and the shadow register.
  - On each shift cycle the LFSR moves one place toward its MSB, and bit 0 takes the XOR of the bits selected by `TAP_MASK`.
  - The default is 16 stages with mask 0xB400.
  - With `extraIn` low, tree t of a deterministic run carries LFSR bit (t mod trees-per-group).
- R3: In phase 0, tree t takes a 2-bit code from `weightCode[2t+1:2t]`. Let a = LFSR bit (t mod W) and b = LFSR bit ((t+W/2) mod W).
  - Code 00 sends a, giving a probability of 1/2.
  - Code 01 sends a AND b, giving 1/4.
  - Code 10 sends a OR b, giving 3/4.
  - Code 11 disables the tree: its scan enable and scan-in stay 0.
- R4: In phase 1, tree t belongs to group t / trees-per-group. Exactly one group enable is high on each shift cycle, groups go in ascending order, and only trees of that group are enabled; the weight codes are ignored.
- R5: Between two consecutive groups of phase 1 there is exactly one non-shifting cycle, in which the LFSR is restored from the shadow copy of the seed. With `extraIn` held low, every group therefore receives the same bit sequence.
- R6: On every phase-1 shift cycle, `extraIn` is XORed into the LFSR feedback bit; in phase 0 it is ignored.
- R7: Each group is shifted for exactly `TREE_DEPTH` cycles. Phase 0 is one such pass with all groups enabled together.
- R8: While idle or in reset, `scanEn`, `groupEn` and `scanIn` are all 0.
- R9: `busy` rises in the cycle after `start` is accepted. `done` is high for exactly one cycle, the cycle after the last shift cycle, with `busy` still high; the block is idle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request, sampled when idle |
| phaseSel | input | 1 | 0 weighted pseudorandom, 1 deterministic |
| seedIn | input | LFSR_W | Seed captured at start |
| extraIn | input | 1 | Variable XORed into feedback in phase 1 shifts |
| weightCode | input | 2*NUM_TREES | Per-tree weight or disable code |
| scanIn | output | NUM_TREES | Scan-in bit per tree |
| scanEn | output | NUM_TREES | Scan enable per tree |
| groupEn | output | NUM_GROUPS | Active group enables |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Every output is a function of registered state and the live weight codes. A start accepted at one edge therefore shows its first shift data in the very next cycle. Each edge adds one step of the LFSR or of the sequencer, and `done` appears one cycle after the last shift.

The bench keeps a behavioural model that advances at each rising edge on the same inputs. It compares all outputs at the following falling edge, after the inputs that were driven shortly past the rising edge have settled. Separate counters check run length, enabled-cycle count and group-to-group equality of the restored sequence.

// File: rtl/lp_bist_pkg.sv
package lp_bist_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_RESTORE,
    ST_FIN
  } bistState_e;

  typedef struct packed {
    logic loadSeed;
    logic restoreSeed;
    logic shiftEn;
    logic detMode;
  } bistCtl_t;

endpackage

// File: rtl/lp_bist_ctrl.sv
module lp_bist_ctrl
  import lp_bist_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int TREE_DEPTH = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  phaseSel,
  output bistCtl_t              ctl,
  output logic [NUM_GROUPS-1:0] groupEn,
  output logic                  busy,
  output logic                  done
);
  localparam int CW = (TREE_DEPTH > 1) ? $clog2(TREE_DEPTH) : 1;
  localparam int GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(TREE_DEPTH - 1);
  localparam logic [GW-1:0] LAST_GRP = GW'(NUM_GROUPS - 1);

  bistState_e state;
  logic [CW-1:0] shiftCnt;
  logic [GW-1:0] grpIdx;
  logic phaseReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      shiftCnt <= '0;
      grpIdx   <= '0;
      phaseReg <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            phaseReg <= phaseSel;
            shiftCnt <= '0;
            grpIdx   <= '0;
            state    <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (shiftCnt == LAST_CNT) begin
            shiftCnt <= '0;
            if (!phaseReg || grpIdx == LAST_GRP) begin
              state <= ST_FIN;
            end else begin
              grpIdx <= grpIdx + 1'b1;
              state  <= ST_RESTORE;
            end
          end else begin
            shiftCnt <= shiftCnt + 1'b1;
          end
        end
        ST_RESTORE: state <= ST_SHIFT;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.loadSeed    = (state == ST_IDLE) && start;
    ctl.restoreSeed = (state == ST_RESTORE);
    ctl.shiftEn     = (state == ST_SHIFT);
    ctl.detMode     = phaseReg;
    busy            = (state != ST_IDLE);
    done            = (state == ST_FIN);
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGrpEn
    assign groupEn[g] = (state == ST_SHIFT) && (!phaseReg || grpIdx == GW'(g));
  end

  // R4: at most one group active in the deterministic phase
  a_r4_group_onehot: assert property (@(posedge clk) disable iff (!rstN)
    ctl.detMode |-> $onehot0(groupEn));
  // R9: done is a single-cycle pulse followed by idle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));
  // R8: no group enabled while idle
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (groupEn == '0));
  // R1: a run in progress is not cut short by start
  a_r1_run_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);
  // R5: a restore cycle is always followed by shifting
  a_r5_restore_then_shift: assert property (@(posedge clk) disable iff (!rstN)
    ctl.restoreSeed |=> ctl.shiftEn);
endmodule

// File: rtl/lp_bist_dp.sv
module lp_bist_dp
  import lp_bist_pkg::*;
#(
  parameter int                LFSR_W     = 16,
  parameter logic [LFSR_W-1:0] TAP_MASK   = 16'hB400,
  parameter int                NUM_TREES  = 8,
  parameter int                NUM_GROUPS = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  bistCtl_t               ctl,
  input  logic [NUM_GROUPS-1:0]  groupEn,
  input  logic [LFSR_W-1:0]      seedIn,
  input  logic                   extraIn,
  input  logic [2*NUM_TREES-1:0] weightCode,
  output logic [NUM_TREES-1:0]   scanIn,
  output logic [NUM_TREES-1:0]   scanEn
);
  localparam int TPG = NUM_TREES / NUM_GROUPS;

  logic [LFSR_W-1:0] lfsr;
  logic [LFSR_W-1:0] shadow;
  logic feedBit;

  assign feedBit = (^(lfsr & TAP_MASK)) ^ (ctl.detMode & extraIn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr   <= '0;
      shadow <= '0;
    end else if (ctl.loadSeed) begin
      lfsr   <= seedIn;
      shadow <= seedIn;
    end else if (ctl.restoreSeed) begin
      lfsr <= shadow;
    end else if (ctl.shiftEn) begin
      lfsr <= {lfsr[LFSR_W-2:0], feedBit};
    end
  end

  for (genvar t = 0; t < NUM_TREES; t++) begin : gTree
    localparam int TA  = t % LFSR_W;
    localparam int TB  = (t + LFSR_W / 2) % LFSR_W;
    localparam int TD  = (t % TPG) % LFSR_W;
    localparam int GRP = t / TPG;
    logic [1:0] code;
    logic treeOff;
    logic wBit;
    assign code    = weightCode[2*t +: 2];
    assign treeOff = !ctl.detMode && (code == 2'b11);
    always_comb begin
      case (code)
        2'b01:   wBit = lfsr[TA] & lfsr[TB];
        2'b10:   wBit = lfsr[TA] | lfsr[TB];
        default: wBit = lfsr[TA];
      endcase
    end
    assign scanEn[t] = ctl.shiftEn && groupEn[GRP] && !treeOff;
    assign scanIn[t] = scanEn[t] && (ctl.detMode ? lfsr[TD] : wBit);
  end

  // R2: seed lands in both registers on the accepting edge
  a_r2_seed_load: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadSeed |=> (lfsr == $past(seedIn) && shadow == $past(seedIn)));
  // R5: restore copies the shadow seed in one cycle
  a_r5_restore_seed: assert property (@(posedge clk) disable iff (!rstN)
    ctl.restoreSeed |=> (lfsr == $past(shadow)));
  // R5: the shadow copy only changes at a new start
  a_r5_shadow_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadSeed |=> $stable(shadow));
  // R8: no scan enable outside shift cycles
  a_r8_no_enable_idle: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.shiftEn |-> (scanEn == '0 && scanIn == '0));
  // R6: in phase 0 the external variable does not reach the register
  a_r6_no_inject_ph0: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.shiftEn && !ctl.detMode && !ctl.restoreSeed && !ctl.loadSeed)
      |=> (lfsr[0] == ^($past(lfsr) & TAP_MASK)));
endmodule

// File: rtl/lp_reseed_bist.sv
module lp_reseed_bist
  import lp_bist_pkg::*;
#(
  parameter int                LFSR_W     = 16,
  parameter logic [LFSR_W-1:0] TAP_MASK   = 16'hB400,
  parameter int                NUM_TREES  = 8,
  parameter int                NUM_GROUPS = 4,
  parameter int                TREE_DEPTH = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic                   phaseSel,
  input  logic [LFSR_W-1:0]      seedIn,
  input  logic                   extraIn,
  input  logic [2*NUM_TREES-1:0] weightCode,
  output logic [NUM_TREES-1:0]   scanIn,
  output logic [NUM_TREES-1:0]   scanEn,
  output logic [NUM_GROUPS-1:0]  groupEn,
  output logic                   busy,
  output logic                   done
);
  bistCtl_t ctl;

  lp_bist_ctrl #(
    .NUM_GROUPS(NUM_GROUPS),
    .TREE_DEPTH(TREE_DEPTH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .phaseSel(phaseSel),
    .ctl(ctl), .groupEn(groupEn), .busy(busy), .done(done)
  );

  lp_bist_dp #(
    .LFSR_W(LFSR_W), .TAP_MASK(TAP_MASK),
    .NUM_TREES(NUM_TREES), .NUM_GROUPS(NUM_GROUPS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .groupEn(groupEn),
    .seedIn(seedIn), .extraIn(extraIn), .weightCode(weightCode),
    .scanIn(scanIn), .scanEn(scanEn)
  );
endmodule

// File: tb/sim_lp_reseed_bist.sv
module sim_lp_reseed_bist;
  localparam int W = 16;
  localparam logic [15:0] TAP = 16'hB400;
  localparam int T = 8;
  localparam int G = 4;
  localparam int D = 8;
  localparam int TPG = T / G;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic phaseSel = 1'b0;
  logic [W-1:0] seedIn = '0;
  logic extraIn = 1'b0;
  logic [2*T-1:0] weightCode = '0;
  logic [T-1:0] scanIn, scanEn;
  logic [G-1:0] groupEn;
  logic busy, done;

  always #4 clk = ~clk;

  lp_reseed_bist u0 (
    .clk(clk), .rstN(rstN), .start(start), .phaseSel(phaseSel),
    .seedIn(seedIn), .extraIn(extraIn), .weightCode(weightCode),
    .scanIn(scanIn), .scanEn(scanEn), .groupEn(groupEn),
    .busy(busy), .done(done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit xMode = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // behavioural model: 0 idle, 1 shift, 2 restore, 3 finish
  int mSt = 0, mCnt = 0, mGrp = 0;
  bit mPh = 0;
  logic [W-1:0] mL = '0, mS = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mCnt = 0; mGrp = 0; mPh = 0; mL = '0; mS = '0;
    end else begin
      case (mSt)
        0: if (start) begin
             mPh = phaseSel; mL = seedIn; mS = seedIn;
             mCnt = 0; mGrp = 0; mSt = 1;
           end
        1: begin
             mL = {mL[W-2:0], (^(mL & TAP)) ^ (mPh & extraIn)};
             if (mCnt == D - 1) begin
               mCnt = 0;
               if (!mPh || mGrp == G - 1) mSt = 3;
               else begin mGrp++; mSt = 2; end
             end else mCnt++;
           end
        2: begin mL = mS; mSt = 1; end
        default: mSt = 0;
      endcase
    end
  end

  int runBusy = 0, runEn = 0;
  bit capOn = 0;
  logic [1:0] rec [G][D];
  int recIdx [G];

  always @(negedge clk) begin
    logic [T-1:0] eEn, eIn;
    logic [G-1:0] eGrp;
    string tEn, tIn;
    eEn = '0; eIn = '0; eGrp = '0;
    if (mSt == 1) begin
      for (int g = 0; g < G; g++) eGrp[g] = !mPh || (g == mGrp);
      for (int t = 0; t < T; t++) begin
        logic [1:0] c;
        logic a, b;
        c = weightCode[2*t +: 2];
        a = mL[t % W];
        b = mL[(t + W/2) % W];
        if (mPh) begin
          eEn[t] = ((t / TPG) == mGrp);
          eIn[t] = eEn[t] & mL[t % TPG];
        end else begin
          eEn[t] = (c != 2'b11);
          eIn[t] = eEn[t] & ((c == 2'b01) ? (a & b) : (c == 2'b10) ? (a | b) : a);
        end
      end
    end
    tEn = (mSt == 0) ? "R8" : (mPh ? "R4" : "R3");
    tIn = (mSt == 0) ? "R8" : (mPh ? (xMode ? "R6" : "R2") : "R3");
    chk(busy == (mSt != 0), "R9", "busy", busy, mSt != 0);
    chk(done == (mSt == 3), "R9", "done", done, mSt == 3);
    chk(groupEn == eGrp, (mSt == 0) ? "R8" : "R4", "groupEn", groupEn, eGrp);
    chk(scanEn == eEn, tEn, "scanEn", scanEn, eEn);
    chk(scanIn == eIn, tIn, "scanIn", scanIn, eIn);
    if (busy) runBusy++;
    if (|scanEn) runEn++;
    if (capOn && groupEn != '0) begin
      for (int g = 0; g < G; g++)
        if (groupEn[g] && recIdx[g] < D) begin
          rec[g][recIdx[g]] = scanIn[TPG*g +: 2];
          recIdx[g]++;
        end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      extraIn = xMode ? 1'($urandom % 2) : 1'b0;
    end
  endtask

  task automatic runOne(input bit ph, input logic [W-1:0] seed,
                        input logic [2*T-1:0] codes, input bit xm,
                        input bit midStart, input int expEn);
    int expBusy;
    expBusy = ph ? (G * D + G) : (D + 1);
    @(posedge clk); #2;
    xMode = xm; phaseSel = ph; seedIn = seed; weightCode = codes;
    runBusy = 0; runEn = 0;
    for (int g = 0; g < G; g++) recIdx[g] = 0;
    start = 1'b1;
    cyc(1);
    start = 1'b0;
    if (midStart) begin
      cyc(4);
      start = 1'b1; phaseSel = ~ph; seedIn = ~seed;
      cyc(1);
      start = 1'b0;
    end
    cyc(expBusy + 3);
    chk(runBusy == expBusy, "R1", "busy length", runBusy, expBusy);
    chk(runEn == expEn, "R7", "enabled shift cycles", runEn, expEn);
  endtask

  initial begin
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(scanEn == '0 && groupEn == '0 && scanIn == '0 && !busy && !done,
        "R8", "reset outputs", {scanEn, scanIn}, 0);
    @(posedge clk); #2;
    rstN = 1'b1;
    cyc(2);
    // phase 0 mixed weights incl. a disabled tree, extra input toggling (R3, R6)
    runOne(1'b0, 16'hACE1, 16'b11_10_01_00_11_10_01_00, 1'b1, 1'b0, D);
    // phase 0 all trees disabled (R3)
    runOne(1'b0, 16'h5A5A, 16'hFFFF, 1'b0, 1'b0, 0);
    // phase 1 without extra variables: groups repeat the seed stream (R5)
    capOn = 1;
    runOne(1'b1, 16'h1234, 16'h0000, 1'b0, 1'b0, G * D);
    capOn = 0;
    for (int g = 1; g < G; g++)
      for (int i = 0; i < D; i++)
        chk(rec[g][i] == rec[0][i], "R5", "group replay", rec[g][i], rec[0][i]);
    // phase 1 with extra variables and a start during the run (R1, R6)
    runOne(1'b1, 16'hBEEF, 16'hFFFF, 1'b1, 1'b1, G * D);
    // phase 0 with a start during the run (R1)
    runOne(1'b0, 16'h0F0F, 16'h1B1B, 1'b0, 1'b1, D);
    // zero seed, extra variables only (R6)
    runOne(1'b1, 16'h0000, 16'h0000, 1'b1, 1'b0, G * D);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule